// File: doc/BRIEF.md
# Timer Overflow Counter With Capture

This block extends a free-running hardware timer with a 20-bit count of its wraps. Each wrap pulse from the base timer increments the count. Software reaches the count through a byte-wide register bus. The accesses are made atomic with two rules. A read of the low byte freezes the upper bytes for the reads that follow. Writes to the two lower bytes collect in a shadow register, and a write of the top byte loads all three bytes at once.

A rising edge on the asynchronous frame-start status input is synchronized and reduced to a single strobe. That strobe copies the timer value into a capture register. In the same cycle it copies the overflow count into the registers that also hold the overflow threshold. The count is compared against the threshold with greater-or-equal.

There are three event sources: timer wrap, timer compare and threshold reached. Each one sets a sticky flag. Each flag is gated by its own mask onto an interrupt request. Two single-cycle DMA trigger pulses follow the timer compare and timer wrap events.

Top module: `ovf_capture_timer`

## Requirements
- R1: Each cycle with `tmr_wrap` high and no count commit increments the overflow count by exactly one.
- R2: A read of address 0 returns count bits [7:0] and freezes bits [19:8]. Reads of address 1 (bits [15:8]) and address 2 (bits [19:16] in [3:0], upper bits zero) return the frozen value until address 0 is read again.
- R3: Writes to addresses 0 and 1 load a shadow and leave the count unchanged. A write to address 2 loads the count with {data[3:0], shadow1, shadow0}.
- R4: A write to address 2 changes the count only while `cnt_wr_allow` is high. Otherwise it is ignored.
- R5: The count wraps from 0xFFFFF to 0 on an increment.
- R6: If a commit and `tmr_wrap` occur in the same cycle, the count takes the written value.
- R7: Each rising edge of `frame_start` produces exactly one capture. The capture stores `tmr_value` at addresses 3 (low) and 4 (high), and the count at threshold addresses 5, 6 and 7 (bits [3:0]). This happens on the third clock edge after the input rises. A level held high does not capture again.
- R8: Threshold reset value is 0xFFFFF. The threshold-reached flag (flag bit 2) is set when the count becomes greater than or equal to the threshold. The condition may arise from a count change or from a threshold change.
- R9: Address 7 bits [7:5] are the masks for the overflow, compare and threshold sources, in that order. Bit 4 reads zero. If a capture coincides with a write to address 7, the threshold nibble takes the captured count and the mask bits keep their old value.
- R10: Flag bits at address 8 are: bit 0 timer wrap, bit 1 timer compare, bit 2 threshold reached. `irq_req` uses the same order. Flags are set by their events regardless of mask. Writing 1 to a flag bit clears it, but a set in the same cycle wins. `irq_req[i]` is high only while flag i and mask i are both set.
- R11: `dma_ovf` and `dma_cmp` go high for one cycle, in the cycle after `tmr_wrap` or `tmr_cmp` is sampled.
- R12: After reset the count, capture registers, masks and flags are zero, the threshold is 0xFFFFF, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_value | input | 16 | Current base timer value |
| tmr_wrap | input | 1 | Base timer wrap pulse |
| tmr_cmp | input | 1 | Base timer compare pulse |
| cnt_wr_allow | input | 1 | High while the timer is idle or running; permits count commits |
| frame_start | input | 1 | Asynchronous frame-start status |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (address 0 read freezes upper bytes) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| int_flags | output | 3 | Sticky event flags |
| irq_req | output | 3 | Masked interrupt requests |
| dma_cmp | output | 1 | DMA trigger on timer compare |
| dma_ovf | output | 1 | DMA trigger on timer wrap |

## Verification
A wrong count or shadow value shows up the next time the three count bytes are read back, which can be any time after the fault. A broken freeze shows as a read that mixes bytes from before and after a carry. A broken synchronizer shows as a capture that lands a cycle off, or as a second capture while the input stays high. In the second case the capture registers change while the timer value is moved. A threshold or flag fault appears at `int_flags` and `irq_req` one cycle after the count or threshold changes.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  localparam int unsigned N_SRC = 3;
  localparam int unsigned SRC_WRAP = 0;
  localparam int unsigned SRC_CMP = 1;
  localparam int unsigned SRC_THR = 2;
  localparam logic [3:0] ADR_CNT0 = 4'd0;
  localparam logic [3:0] ADR_CNT1 = 4'd1;
  localparam logic [3:0] ADR_CNT2 = 4'd2;
  localparam logic [3:0] ADR_CAPL = 4'd3;
  localparam logic [3:0] ADR_CAPH = 4'd4;
  localparam logic [3:0] ADR_THR0 = 4'd5;
  localparam logic [3:0] ADR_THR1 = 4'd6;
  localparam logic [3:0] ADR_THR2 = 4'd7;
  localparam logic [3:0] ADR_FLAG = 4'd8;
endpackage

// File: rtl/ovt_edge_sync.sv
module ovt_edge_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [SYNC_N:0] sh_q;
  logic [SYNC_N:0] sh_d;

  // stage 0 samples the raw input; the last stage is the edge reference
  always_comb begin
    sh_d = {sh_q[SYNC_N-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
endmodule

// File: rtl/ovt_count_unit.sv
module ovt_count_unit #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             sh_we0,
  input  logic             sh_we1,
  input  logic             commit,
  input  logic             rd_lo,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-9:0] hi_frz
);
  localparam int unsigned HI_W  = CNT_W - 8;
  localparam int unsigned TOP_W = CNT_W - 16;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [7:0]       sh0_q, sh1_q;
  logic [HI_W-1:0]  frz_q, frz_d;

  // a commit outranks an increment in the same cycle
  always_comb begin
    cnt_en = commit | inc;
    if (commit)            cnt_d = {wdata[TOP_W-1:0], sh1_q, sh0_q};
    else if (cnt_q == '1)  cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
    frz_d = cnt_q[CNT_W-1:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh0_q <= '0;
      sh1_q <= '0;
      frz_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (sh_we0) sh0_q <= wdata;
      if (sh_we1) sh1_q <= wdata;
      if (rd_lo)  frz_q <= frz_d;
    end
  end

  assign cnt    = cnt_q;
  assign hi_frz = frz_q;
endmodule

// File: rtl/ovt_thresh_unit.sv
module ovt_thresh_unit #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we0,
  input  logic             we1,
  input  logic             we2,
  input  logic [7:0]       wbyte,
  input  logic             cap_stb,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] thr,
  output logic [2:0]       mask,
  output logic             thr_evt
);
  localparam int unsigned TOP_W = CNT_W - 16;

  logic [CNT_W-1:0] thr_q, thr_d;
  logic             thr_en;
  logic [2:0]       msk_q, msk_d;
  logic             msk_en;
  logic             ge_now, ge_q;

  always_comb begin
    thr_d = thr_q;
    if (we0) thr_d[7:0]        = wbyte;
    if (we1) thr_d[15:8]       = wbyte;
    if (we2) thr_d[CNT_W-1:16] = wbyte[TOP_W-1:0];
    if (cap_stb) thr_d = cnt;
    thr_en = we0 | we1 | we2 | cap_stb;
    // a capture blocks the mask update of a coinciding top-byte write
    msk_en = we2 & ~cap_stb;
    msk_d  = wbyte[7:5];
    ge_now = (cnt >= thr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '1;
      msk_q <= '0;
      ge_q  <= 1'b0;
    end else begin
      if (thr_en) thr_q <= thr_d;
      if (msk_en) msk_q <= msk_d;
      ge_q <= ge_now;
    end
  end

  assign thr     = thr_q;
  assign mask    = msk_q;
  assign thr_evt = ge_now & ~ge_q;
endmodule

// File: rtl/ovt_flag_unit.sv
module ovt_flag_unit #(
  parameter int unsigned NS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] evt,
  input  logic          clr_we,
  input  logic [NS-1:0] clr_bits,
  input  logic [NS-1:0] mask,
  output logic [NS-1:0] flags,
  output logic [NS-1:0] irq
);
  logic [NS-1:0] flg_q, flg_d, clr;

  always_comb begin
    clr   = clr_we ? clr_bits : '0;
    flg_d = (flg_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_irq
      assign irq[gi] = flg_q[gi] & mask[gi];
    end
  endgenerate

  assign flags = flg_q;
endmodule

// File: rtl/ovf_capture_timer.sv
module ovf_capture_timer
  import ovt_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned TMR_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmr_value,
  input  logic             tmr_wrap,
  input  logic             tmr_cmp,
  input  logic             cnt_wr_allow,
  input  logic             frame_start,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [N_SRC-1:0] int_flags,
  output logic [N_SRC-1:0] irq_req,
  output logic             dma_cmp,
  output logic             dma_ovf
);
  localparam int unsigned HI_W = CNT_W - 8;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             cap_stb;
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  hi_frz;
  logic [CNT_W-1:0] thr;
  logic [2:0]       mask;
  logic             thr_evt;
  logic [TMR_W-1:0] cap_q;
  logic [15:0]      cap_ext;
  logic [N_SRC-1:0] evt;
  logic             dcmp_q, dovf_q;
  logic             we_c0, we_c1, commit, rd_lo;
  logic             we_t0, we_t1, we_t2, we_f;

  // reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    we_c0  = bus_wr && (bus_addr == ADR_CNT0);
    we_c1  = bus_wr && (bus_addr == ADR_CNT1);
    commit = bus_wr && (bus_addr == ADR_CNT2) && cnt_wr_allow;
    rd_lo  = bus_rd && (bus_addr == ADR_CNT0);
    we_t0  = bus_wr && (bus_addr == ADR_THR0);
    we_t1  = bus_wr && (bus_addr == ADR_THR1);
    we_t2  = bus_wr && (bus_addr == ADR_THR2);
    we_f   = bus_wr && (bus_addr == ADR_FLAG);
  end

  ovt_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(frame_start), .rise(cap_stb)
  );

  ovt_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .inc(tmr_wrap), .sh_we0(we_c0),
    .sh_we1(we_c1), .commit(commit), .rd_lo(rd_lo), .wdata(bus_wdata),
    .cnt(cnt_q), .hi_frz(hi_frz)
  );

  ovt_thresh_unit #(.CNT_W(CNT_W)) u_thr (
    .clk(clk), .rst_n(rst_int_n), .we0(we_t0), .we1(we_t1), .we2(we_t2),
    .wbyte(bus_wdata), .cap_stb(cap_stb), .cnt(cnt_q), .thr(thr),
    .mask(mask), .thr_evt(thr_evt)
  );

  always_comb begin
    evt = '0;
    evt[SRC_WRAP] = tmr_wrap;
    evt[SRC_CMP]  = tmr_cmp;
    evt[SRC_THR]  = thr_evt;
  end

  ovt_flag_unit #(.NS(N_SRC)) u_flg (
    .clk(clk), .rst_n(rst_int_n), .evt(evt), .clr_we(we_f),
    .clr_bits(bus_wdata[N_SRC-1:0]), .mask(mask), .flags(int_flags),
    .irq(irq_req)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cap_q  <= '0;
      dcmp_q <= 1'b0;
      dovf_q <= 1'b0;
    end else begin
      if (cap_stb) cap_q <= tmr_value;
      dcmp_q <= tmr_cmp;
      dovf_q <= tmr_wrap;
    end
  end
  assign dma_cmp = dcmp_q;
  assign dma_ovf = dovf_q;
  assign cap_ext = 16'(cap_q);

  always_comb begin
    case (bus_addr)
      ADR_CNT0: bus_rdata = cnt_q[7:0];
      ADR_CNT1: bus_rdata = hi_frz[7:0];
      ADR_CNT2: bus_rdata = 8'(hi_frz[HI_W-1:8]);
      ADR_CAPL: bus_rdata = cap_ext[7:0];
      ADR_CAPH: bus_rdata = cap_ext[15:8];
      ADR_THR0: bus_rdata = thr[7:0];
      ADR_THR1: bus_rdata = thr[15:8];
      ADR_THR2: bus_rdata = {mask, 1'b0, 4'(thr[CNT_W-1:16])};
      ADR_FLAG: bus_rdata = 8'(int_flags);
      default:  bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/ovf_capture_timer_chk.sv
module ovf_capture_timer_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_wrap,
  input logic             tmr_cmp,
  input logic             cnt_wr_allow,
  input logic [3:0]       bus_addr,
  input logic             bus_wr,
  input logic [7:0]       bus_wdata,
  input logic [2:0]       int_flags,
  input logic             dma_cmp,
  input logic             dma_ovf,
  input logic [CNT_W-1:0] cnt,
  input logic             cap_stb
);
  localparam int unsigned TOP_W = CNT_W - 16;
  logic commit_w, clr_cmp_w;
  assign commit_w  = bus_wr && (bus_addr == 4'd2) && cnt_wr_allow;
  assign clr_cmp_w = bus_wr && (bus_addr == 4'd8) && bus_wdata[1];

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wrap && !commit_w) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wrap && !commit_w) |=> $stable(cnt)); // R4
  AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> (cnt[CNT_W-1:16] == $past(bus_wdata[TOP_W-1:0]))); // R6
  AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> !cap_stb); // R7
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> int_flags[0]); // R10
  AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flags[1] && !clr_cmp_w) |=> int_flags[1]); // R10
  AST_DMA_OVF_ON: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> dma_ovf); // R11
  AST_DMA_OVF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wrap |=> !dma_ovf); // R11
  AST_DMA_CMP_ON: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cmp |=> dma_cmp); // R11
  AST_DMA_CMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_cmp |=> !dma_cmp); // R11
endmodule

bind ovf_capture_timer ovf_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .tmr_wrap(tmr_wrap), .tmr_cmp(tmr_cmp),
  .cnt_wr_allow(cnt_wr_allow), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .int_flags(int_flags), .dma_cmp(dma_cmp),
  .dma_ovf(dma_ovf), .cnt(cnt_q), .cap_stb(cap_stb)
);

// File: tb/ovf_capture_timer_test.sv
`timescale 1ns/1ps
module ovf_capture_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_value = '0;
  logic        tmr_wrap = 1'b0, tmr_cmp = 1'b0, cnt_wr_allow = 1'b1;
  logic        frame_start = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  int_flags, irq_req;
  logic        dma_cmp, dma_ovf;

  int tests = 0, fails = 0;
  logic done = 1'b0;
  logic [19:0] exp_cnt = '0;

  always #4 clk = ~clk;

  ovf_capture_timer uut (
    .clk(clk), .rst_n(rst_n), .tmr_value(tmr_value), .tmr_wrap(tmr_wrap),
    .tmr_cmp(tmr_cmp), .cnt_wr_allow(cnt_wr_allow), .frame_start(frame_start),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_flags(int_flags),
    .irq_req(irq_req), .dma_cmp(dma_cmp), .dma_ovf(dma_ovf)
  );

  function automatic logic [19:0] nxt(input logic [19:0] v);
    return (v == 20'hFFFFF) ? 20'h0 : v + 20'h1;
  endfunction

  function automatic logic [2:0] gate(input logic [2:0] f, input logic [2:0] m);
    return f & m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_cnt(output logic [19:0] v);
    logic [7:0] b0, b1, b2;
    rd(4'd0, b0); rd(4'd1, b1); rd(4'd2, b2);
    v = {b2[3:0], b1, b0};
  endtask

  task automatic set_cnt(input logic [19:0] v);
    wr(4'd0, v[7:0]); wr(4'd1, v[15:8]); wr(4'd2, {4'h0, v[19:16]});
    if (cnt_wr_allow) exp_cnt = v;
  endtask

  task automatic wraps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmr_wrap = 1'b1;
      @(negedge clk); tmr_wrap = 1'b0;
      exp_cnt = nxt(exp_cnt);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] v;
    logic [7:0] b;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    rd_cnt(v); chk("R12 count", 32'(v), 32'h0);
    rd(4'd5, b); chk("R12 thr0", 32'(b), 32'hFF);
    rd(4'd7, b); chk("R12 thr2/mask", 32'(b), 32'h0F);
    rd(4'd3, b); chk("R12 capl", 32'(b), 32'h0);
    chk("R12 flags", 32'(int_flags), 32'h0);
    chk("R12 irq", 32'(irq_req), 32'h0);
    chk("R12 dma", 32'({dma_cmp, dma_ovf}), 32'h0);

    // R1 increment
    wraps(5); rd_cnt(v); chk("R1 count after 5 wraps", 32'(v), 32'(exp_cnt));

    // R3 shadow then commit
    set_cnt(20'h00010);
    wr(4'd0, 8'hAB); wr(4'd1, 8'hCD);
    rd_cnt(v); chk("R3 unchanged before commit", 32'(v), 32'h00010);
    wr(4'd2, 8'h03); exp_cnt = 20'h3CDAB;
    rd_cnt(v); chk("R3 commit value", 32'(v), 32'h3CDAB);

    // R4 blocked commit
    cnt_wr_allow = 1'b0;
    wr(4'd0, 8'h11); wr(4'd1, 8'h22); wr(4'd2, 8'h09);
    rd_cnt(v); chk("R4 commit ignored", 32'(v), 32'(exp_cnt));
    cnt_wr_allow = 1'b1;

    // R2 freeze across a carry
    set_cnt(20'h000FF);
    rd(4'd0, b); chk("R2 low byte", 32'(b), 32'hFF);
    wraps(1);
    rd(4'd1, b); chk("R2 frozen byte1", 32'(b), 32'h00);
    rd(4'd2, b); chk("R2 frozen byte2", 32'(b), 32'h00);
    rd_cnt(v); chk("R2 refreshed count", 32'(v), 32'h00100);

    // R5 wrap to zero
    set_cnt(20'hFFFFF); wraps(1);
    rd_cnt(v); chk("R5 wrap to zero", 32'(v), 32'h0);

    // R6 commit beats increment
    wr(4'd0, 8'h55); wr(4'd1, 8'h66);
    @(negedge clk); bus_addr = 4'd2; bus_wdata = 8'h07; bus_wr = 1'b1; tmr_wrap = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tmr_wrap = 1'b0; exp_cnt = 20'h76655;
    rd_cnt(v); chk("R6 commit wins", 32'(v), 32'h76655);

    // R7 capture once per rising edge
    set_cnt(20'h51234);
    tmr_value = 16'hBEEF;
    @(negedge clk); frame_start = 1'b1;
    repeat (5) @(negedge clk);
    tmr_value = 16'h1111;
    repeat (5) @(negedge clk);
    rd(4'd3, b); chk("R7 capture low", 32'(b), 32'hEF);
    rd(4'd4, b); chk("R7 capture high", 32'(b), 32'hBE);
    rd(4'd5, b); chk("R7 count byte0", 32'(b), 32'h34);
    rd(4'd6, b); chk("R7 count byte1", 32'(b), 32'h12);
    rd(4'd7, b); chk("R7 count nibble", 32'(b), 32'h05);
    frame_start = 1'b0;
    repeat (4) @(negedge clk);

    // R9 capture collides with top threshold byte write
    wr(4'd7, 8'hE3); rd(4'd7, b); chk("R9 plain write", 32'(b), 32'hE3);
    wr(4'd7, 8'h23);
    set_cnt(20'h70000);
    repeat (3) @(negedge clk);
    @(negedge clk); frame_start = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 4'd7; bus_wdata = 8'hE3; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(4'd7, b); chk("R9 masks kept, nibble captured", 32'(b), 32'h27);
    frame_start = 1'b0;
    repeat (4) @(negedge clk);

    // R8 greater-or-equal compare
    wr(4'd7, 8'h0F);
    set_cnt(20'h00010);
    wr(4'd6, 8'h00); wr(4'd7, 8'h00); wr(4'd5, 8'h12);
    wr(4'd8, 8'h07);
    rd(4'd8, b); chk("R8 below threshold", 32'(b[2]), 32'h0);
    wraps(1); rd(4'd8, b); chk("R8 one below", 32'(b[2]), 32'h0);
    wraps(1); rd(4'd8, b); chk("R8 equal sets flag", 32'(b[2]), 32'h1);
    wr(4'd8, 8'h04); wraps(1);
    rd(4'd8, b); chk("R8 no re-event while above", 32'(b[2]), 32'h0);
    wr(4'd5, 8'hFF); wr(4'd8, 8'h07);
    wr(4'd5, 8'h01);
    rd(4'd8, b); chk("R8 greater via threshold write", 32'(b[2]), 32'h1);

    // R10 flags, masks, clear
    wr(4'd7, 8'hAF); wr(4'd8, 8'h07);
    wraps(1);
    @(negedge clk); tmr_cmp = 1'b1;
    @(posedge clk); #1 chk("R11 dma_cmp high", 32'(dma_cmp), 32'h1);
    @(negedge clk); tmr_cmp = 1'b0;
    @(posedge clk); #1 chk("R11 dma_cmp low", 32'(dma_cmp), 32'h0);
    @(negedge clk);
    chk("R10 flags regardless of mask", 32'(int_flags), 32'h3);
    chk("R10 irq gated", 32'(irq_req), 32'(gate(3'b011, 3'b101)));
    wr(4'd8, 8'h01);
    chk("R10 clear one flag", 32'(int_flags), 32'h2);
    chk("R10 irq after clear", 32'(irq_req), 32'h0);
    @(negedge clk); bus_addr = 4'd8; bus_wdata = 8'h01; bus_wr = 1'b1; tmr_wrap = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tmr_wrap = 1'b0; exp_cnt = nxt(exp_cnt);
    chk("R10 set beats clear", 32'(int_flags[0]), 32'h1);

    // R11 overflow DMA pulse
    @(negedge clk); tmr_wrap = 1'b1;
    @(posedge clk); #1 chk("R11 dma_ovf high", 32'(dma_ovf), 32'h1);
    @(negedge clk); tmr_wrap = 1'b0; exp_cnt = nxt(exp_cnt);
    @(posedge clk); #1 chk("R11 dma_ovf low", 32'(dma_ovf), 32'h0);

    // random mix: R1 R3 R4 R5
    for (int it = 0; it < 300; it++) begin
      int unsigned op;
      op = $urandom % 4;
      if (op < 2) wraps(1 + int'($urandom % 4));
      else if (op == 2) begin
        rd_cnt(v); chk("R1 random count", 32'(v), 32'(exp_cnt));
      end else begin
        logic [19:0] rv;
        rv = ($urandom % 2) ? 20'($urandom) : 20'hFFFFC;
        cnt_wr_allow = ($urandom % 4) != 0;
        set_cnt(rv);
        cnt_wr_allow = 1'b1;
      end
    end
    rd_cnt(v); chk("R3 final count", 32'(v), 32'(exp_cnt));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule